// File: doc/BRIEF.md
# Distributed Clock Offset and Drift Servo

This block keeps a slave node's local nanosecond time counter aligned to the reference node of a line-topology fieldbus. The reference node is the first slave after the master. A compensation message carries the reference node's time, captured when the message passed that node. The block adds two configured sums to that stamp: the cable delay and the forward station-processing delay from the reference node to this node. The result is the reference time at the moment the message reached this node.

An accepted message sets the integer part of the local time to the reconstructed reference time, which removes the offset. From the second message after reset, the block also compares how much reference time and how much local time passed since the previous message. It then rescales the per-tick increment by that ratio, which removes drift. The ratio comes from a sequential divider. While the divider runs, the block reports busy and ignores new messages. The new increment takes effect in a single step when the division ends.

Top module: `dc_servo`

## Requirements
- R1: The time register is 64 bits wide with 24 fraction bits. Each clock it adds the increment, which is unsigned fixed point with 8 integer and 24 fraction bits. `local_time_o` is bits [63:24] of the register.
- R2: After reset, `local_time_o` is 0, `rate_o` equals `INC_RESET` (default 0x0800_0000, which is 8 ns per tick) and `busy_o` is 0.
- R3: A message is accepted when `msg_valid_i` is high at a clock edge and `busy_o` is low. At that edge the register becomes {ref, old fraction} + increment, where ref = `msg_ts_i` + `cable_dly_i` + `station_dly_i`, computed modulo 2^40.
- R4: With both delay inputs at zero (the reference node), ref equals `msg_ts_i`.
- R5: The first message accepted after reset corrects only the offset. `rate_o` does not change and `busy_o` stays low.
- R6: Each later accepted message computes a new rate. It takes ld = (local_time_o at arrival − previous ref) and rd = (ref − previous ref), both as the low 32 bits unsigned. The new rate is floor(rate × rd / ld), saturating at 0xFFFF_FFFF.
- R7: After a drift message, `busy_o` is high for exactly 64 clocks. The new rate is loaded at the same edge where `busy_o` falls. Every tick until then, including that edge, uses the old rate.
- R8: A message that arrives while `busy_o` is high is ignored: the time keeps counting at the current rate and the pending rate result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_valid_i | input | 1 | Compensation message strobe |
| msg_ts_i | input | 40 | Reference timestamp carried by the message, ns |
| cable_dly_i | input | 32 | Summed cable delay from the reference node, ns |
| station_dly_i | input | 32 | Summed forward station delay from the reference node, ns |
| local_time_o | output | 40 | Integer ns of the local time |
| rate_o | output | 32 | Current increment, 8.24 fixed point |
| busy_o | output | 1 | Rate division in progress; messages ignored |

## Verification
The bench first checks that a first message only sets the time. A design that ran the divider on it would raise busy and load a rate computed from a reset value. It then checks that the new rate appears exactly at the 64th edge and that the edge itself still counts at the old rate. An off-by-one there would show as a single tick of the wrong size. A message sent during the division must leave the time on its old trajectory, so a design that still applied the offset would jump. A large reference delta over a short local interval must saturate the rate; a design that truncated instead would wrap to a small rate. Fractional rates are run long enough for carries out of the fraction to show up at the integer output.

// File: rtl/dc_servo_pkg.sv
package dc_servo_pkg;
  localparam int unsigned FRAC_W = 24;

  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/dc_ref_calc.sv
module dc_ref_calc #(
  parameter int unsigned INT_W   = 40,
  parameter int unsigned DLY_W   = 32,
  parameter int unsigned DELTA_W = 32
) (
  input  logic [INT_W-1:0]   ts_i,
  input  logic [DLY_W-1:0]   cable_i,
  input  logic [DLY_W-1:0]   station_i,
  input  logic [INT_W-1:0]   loc_i,
  input  logic [INT_W-1:0]   prev_ref_i,
  output logic [INT_W-1:0]   ref_o,
  output logic [DELTA_W-1:0] ref_delta_o,
  output logic [DELTA_W-1:0] loc_delta_o
);
  always_comb begin
    ref_o       = ts_i + INT_W'(cable_i) + INT_W'(station_i);
    ref_delta_o = DELTA_W'(ref_o - prev_ref_i);
    // local elapsed since last correction (local time was set to prev ref)
    loc_delta_o = DELTA_W'(loc_i - prev_ref_i);
  end
endmodule

// File: rtl/dc_rate_div.sv
module dc_rate_div
  import dc_servo_pkg::*;
#(
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 32,
  parameter int unsigned Q_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             upd_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic             dz_q;

  logic [DEN_W:0]   rem_sh;
  logic [DEN_W-1:0] rem_nx;
  logic [NUM_W-1:0] quo_nx;
  logic             done;

  always_comb begin
    rem_sh = {rem_q, quo_q[NUM_W-1]};
    quo_nx = {quo_q[NUM_W-2:0], 1'b0};
    rem_nx = DEN_W'(rem_sh);
    if (rem_sh >= {1'b0, den_q}) begin
      rem_nx    = DEN_W'(rem_sh - {1'b0, den_q});
      quo_nx[0] = 1'b1;
    end
  end

  assign done   = (state_q == DIV_RUN) && (cnt_q == CNT_W'(1));
  assign busy_o = (state_q == DIV_RUN);
  assign upd_o  = done && !dz_q;
  assign quo_o  = (|quo_nx[NUM_W-1:Q_W]) ? {Q_W{1'b1}} : quo_nx[Q_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      dz_q    <= 1'b0;
    end else if (state_q == DIV_IDLE) begin
      if (start_i) begin
        state_q <= DIV_RUN;
        cnt_q   <= CNT_W'(NUM_W);
        rem_q   <= '0;
        den_q   <= den_i;
        quo_q   <= num_i;
        dz_q    <= (den_i == '0);
      end
    end else begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
      cnt_q <= cnt_q - CNT_W'(1);
      if (done) state_q <= DIV_IDLE;
    end
  end
endmodule

// File: rtl/dc_time_acc.sv
module dc_time_acc #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned FRAC_W = 24,
  parameter int unsigned INC_W  = 32,
  localparam int unsigned INT_W = TIME_W - FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INT_W-1:0] load_int_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [INT_W-1:0] time_int_o
);
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (load_i) time_q <= {load_int_i, time_q[FRAC_W-1:0]} + TIME_W'(inc_i);
    else             time_q <= time_q + TIME_W'(inc_i);
  end

  assign time_int_o = time_q[TIME_W-1:FRAC_W];
endmodule

// File: rtl/dc_servo.sv
module dc_servo
  import dc_servo_pkg::*;
#(
  parameter int unsigned   TIME_W    = 64,
  parameter int unsigned   INC_W     = 32,
  parameter int unsigned   DLY_W     = 32,
  parameter int unsigned   DELTA_W   = 32,
  parameter logic [INC_W-1:0] INC_RESET = 32'h0800_0000,
  localparam int unsigned  INT_W     = TIME_W - FRAC_W,
  localparam int unsigned  NUM_W     = INC_W + DELTA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic [INT_W-1:0] msg_ts_i,
  input  logic [DLY_W-1:0] cable_dly_i,
  input  logic [DLY_W-1:0] station_dly_i,
  output logic [INT_W-1:0] local_time_o,
  output logic [INC_W-1:0] rate_o,
  output logic             busy_o
);
  logic [INC_W-1:0]   inc_q;
  logic [INT_W-1:0]   prev_ref_q;
  logic               have_prev_q;
  logic               accept;
  logic [INT_W-1:0]   ref_time;
  logic [DELTA_W-1:0] ref_delta, loc_delta;
  logic               div_busy, div_upd;
  logic [INC_W-1:0]   div_quo;

  assign accept = msg_valid_i && !div_busy;

  dc_ref_calc #(.INT_W(INT_W), .DLY_W(DLY_W), .DELTA_W(DELTA_W)) ref_i (
    .ts_i        (msg_ts_i),
    .cable_i     (cable_dly_i),
    .station_i   (station_dly_i),
    .loc_i       (local_time_o),
    .prev_ref_i  (prev_ref_q),
    .ref_o       (ref_time),
    .ref_delta_o (ref_delta),
    .loc_delta_o (loc_delta)
  );

  dc_rate_div #(.NUM_W(NUM_W), .DEN_W(DELTA_W), .Q_W(INC_W)) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && have_prev_q),
    .num_i   (NUM_W'(inc_q) * NUM_W'(ref_delta)),
    .den_i   (loc_delta),
    .busy_o  (div_busy),
    .upd_o   (div_upd),
    .quo_o   (div_quo)
  );

  dc_time_acc #(.TIME_W(TIME_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) acc_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_int_i (ref_time),
    .inc_i      (inc_q),
    .time_int_o (local_time_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q       <= INC_RESET;
      prev_ref_q  <= '0;
      have_prev_q <= 1'b0;
    end else begin
      if (div_upd) inc_q <= div_quo;
      if (accept) begin
        prev_ref_q  <= ref_time;
        have_prev_q <= 1'b1;
      end
    end
  end

  assign rate_o = inc_q;
  assign busy_o = div_busy;
endmodule

// File: rtl/dc_servo_chk.sv
module dc_servo_chk #(
  parameter int unsigned INT_W = 40,
  parameter int unsigned DLY_W = 32,
  parameter int unsigned INC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_valid_i,
  input logic [INT_W-1:0] msg_ts_i,
  input logic [DLY_W-1:0] cable_dly_i,
  input logic [DLY_W-1:0] station_dly_i,
  input logic [INT_W-1:0] local_time_o,
  input logic [INC_W-1:0] rate_o,
  input logic             busy_o,
  input logic             accept,
  input logic             have_prev_q
);
  logic [INT_W-1:0] ref_sum;
  assign ref_sum = msg_ts_i + INT_W'(cable_dly_i) + INT_W'(station_dly_i);

  AST_TICK_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> (local_time_o - $past(local_time_o)) <= INT_W'(256)); // R1
  AST_OFFSET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (local_time_o - $past(ref_sum)) <= INT_W'(256)); // R3
  AST_FIRST_NO_DRIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !have_prev_q |=> !busy_o && $stable(rate_o)); // R5
  AST_DRIFT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && have_prev_q |=> busy_o); // R7
  AST_RATE_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_o) |-> $fell(busy_o)); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && msg_valid_i |=> (local_time_o - $past(local_time_o)) <= INT_W'(256)); // R8
endmodule

bind dc_servo dc_servo_chk #(.INT_W(INT_W), .DLY_W(DLY_W), .INC_W(INC_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .msg_valid_i   (msg_valid_i),
  .msg_ts_i      (msg_ts_i),
  .cable_dly_i   (cable_dly_i),
  .station_dly_i (station_dly_i),
  .local_time_o  (local_time_o),
  .rate_o        (rate_o),
  .busy_o        (busy_o),
  .accept        (accept),
  .have_prev_q   (have_prev_q)
);

// File: tb/dc_servo_tb_top.sv
module dc_servo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [39:0] ts = '0;
  logic [31:0] cab = '0, sta = '0;
  logic [39:0] lt;
  logic [31:0] rate;
  logic        busy;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_servo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(valid), .msg_ts_i(ts),
    .cable_dly_i(cab), .station_dly_i(sta),
    .local_time_o(lt), .rate_o(rate), .busy_o(busy)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_time;
  logic [31:0] m_inc, m_pend;
  int          m_busy;
  bit          m_have;
  logic [39:0] m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_time = '0; m_inc = 32'h0800_0000; m_pend = '0;
      m_busy = 0; m_have = 0; m_prev = '0;
    end else if (m_busy != 0) begin
      m_time = m_time + 64'(m_inc);
      m_busy--;
      if (m_busy == 0) m_inc = m_pend;
    end else if (valid) begin
      logic [39:0] loc, rf;
      logic [31:0] ld, rd;
      logic [63:0] q;
      loc = m_time[63:24];
      rf = ts + 40'(cab) + 40'(sta);
      m_time = {rf, m_time[23:0]} + 64'(m_inc);
      if (m_have) begin
        ld = 32'(loc - m_prev);
        rd = 32'(rf - m_prev);
        if (ld == 0) m_pend = m_inc;
        else begin
          q = (64'(m_inc) * 64'(rd)) / 64'(ld);
          m_pend = (q > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
        end
        m_busy = 64;
      end
      m_have = 1; m_prev = rf;
    end else begin
      m_time = m_time + 64'(m_inc);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R1 time vs model", 64'(lt), 64'(m_time[63:24]));
      check("R6 rate vs model", 64'(rate), 64'(m_inc));
      check("R7 busy vs model", 64'(busy), 64'(m_busy != 0));
    end
  end

  task automatic drive(input logic [39:0] t, input logic [31:0] c, input logic [31:0] s);
    ts = t; cab = c; sta = s; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [39:0] loc, pr, t0, t1;
    int nb;
    repeat (3) @(negedge clk);
    check("R2 reset time", 64'(lt), 64'd0);
    check("R2 reset rate", 64'(rate), 64'h0800_0000);
    check("R2 reset busy", 64'(busy), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t0 = lt; @(negedge clk);
    check("R1 tick 8ns", 64'(lt - t0), 64'd8);

    // first message: offset only
    @(negedge clk);
    drive(40'd1000, 32'd20, 32'd30);
    check("R3 offset load", 64'(lt), 64'd1058);
    check("R5 no busy", 64'(busy), 64'd0);
    check("R5 rate kept", 64'(rate), 64'h0800_0000);
    pr = 40'd1050;

    // second message: reference runs twice as fast
    repeat (20) @(negedge clk);
    loc = lt;
    drive(pr + 40'd2 * (loc - pr) - 40'd50, 32'd20, 32'd30);
    pr = pr + 40'd2 * (loc - pr);
    check("R3 offset second", 64'(lt), 64'(pr + 40'd8));
    nb = busy ? 1 : 0;
    repeat (62) begin @(negedge clk); if (busy) nb++; end
    t0 = lt;
    @(negedge clk); if (busy) nb++;
    check("R7 busy length", 64'(nb), 64'd64);
    t1 = lt;
    check("R7 old rate on last busy edge", 64'(t1 - t0), 64'd8);
    @(negedge clk);
    check("R7 busy fell", 64'(busy), 64'd0);
    check("R6 doubled rate", 64'(rate), 64'h1000_0000);
    check("R7 old rate on load edge", 64'(lt - t1), 64'd8);
    t0 = lt; @(negedge clk);
    check("R7 new rate in use", 64'(lt - t0), 64'd16);

    // reference node: zero delays, ratio one
    repeat (10) @(negedge clk);
    loc = lt;
    drive(loc, 32'd0, 32'd0);
    check("R4 ref node load", 64'(lt), 64'(loc + 40'd16));
    pr = loc;
    repeat (5) @(negedge clk);
    t0 = lt;
    drive(40'd5, 32'd7, 32'd9);
    check("R8 ignored while busy", 64'(lt - t0), 64'd16);
    wait_idle();
    check("R8 rate unaffected", 64'(rate), 64'h1000_0000);

    // saturation
    repeat (3) @(negedge clk);
    drive(pr + 40'h0_8000_0000, 32'd0, 32'd0);
    pr = pr + 40'h0_8000_0000;
    check("R3 offset big jump", 64'(lt), 64'(pr + 40'd16));
    wait_idle();
    check("R6 saturated rate", 64'(rate), 64'hFFFF_FFFF);

    // fractional rate
    repeat (50) @(negedge clk);
    loc = lt;
    drive(pr + (loc - pr) / 40'd32 + 40'd7, 32'd0, 32'd0);
    pr = pr + (loc - pr) / 40'd32 + 40'd7;
    wait_idle();
    repeat (150) @(negedge clk);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      done_flag = 1;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule